// File: doc/BRIEF.md
# Timekeeping Prescaler with Digital Trim

This block turns a stream of reference tick enables, nominally 32,768 per second, into a one-cycle pulse once per second. It also produces a slow square wave taken straight from the raw reference count, so an external counter can measure the oscillator without any trim applied. An oscillator-stop input freezes all counting, which lets software park the timebase.

Rate trim is digital. Each second is cut into equal slots. In every correction period, a number of slots chosen by a 5-bit magnitude and a direction bit are made one reference tick longer (slow down) or one tick shorter (speed up). The corrected slots are always the first ones of the period, so no slot boundary moves by more than one tick. The trim is asymmetric: one speed-up step removes 8 ticks per period, while one slow-down step adds 4 ticks per period. With the default 60-second period this gives about +4.07 ppm and -2.03 ppm per step. The calibration inputs are captured during reset and again at each period boundary, so software can rewrite them at any time without disturbing a period already in progress.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While reset is held and on the first cycle after its release, `sec_tick_o` and `test_wave_o` are 0, and all counting starts from zero.
- R2: With a magnitude of 0, every second lasts exactly 2^DIV_LOG2 accepted reference ticks, whichever direction bit is set.
- R3: With `cal_speedup_i` = 0 and magnitude m, the first NEG_STEP*m slots of each correction period are one tick longer than nominal, and all other slots are nominal.
- R4: With `cal_speedup_i` = 1 and magnitude m, the first POS_STEP*m slots of each correction period are one tick shorter than nominal, and all other slots are nominal.
- R5: A slot lasts 2^SLOT_LOG2 ticks, plus or minus at most one. Second k of a period holds slots k*S to k*S+S-1, where S = 2^(DIV_LOG2-SLOT_LOG2). A period holds PERIOD_SECS seconds and begins with a second boundary.
- R6: The calibration inputs are sampled during reset and at the last tick of each period. A change made in the middle of a period takes effect only from the next period.
- R7: While `osc_stop_i` = 1, reference ticks are ignored: no `sec_tick_o` pulse occurs, `test_wave_o` holds its level, and counting resumes from where it stopped.
- R8: `test_wave_o` is a square wave with a period of 2^TEST_LOG2 accepted ticks. It starts low, changes level every 2^(TEST_LOG2-1) accepted ticks, and is independent of the trim.
- R9: `sec_tick_o` is high for exactly one clock cycle. That cycle is the one after the clock edge that accepted the last tick of the second.
- R10: A cycle with `ref_tick_i` = 0 advances nothing, so the output timing depends only on the count of accepted ticks and not on how they are spaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | Reference tick enable, one per oscillator period |
| osc_stop_i | input | 1 | 1 freezes the timebase |
| cal_mag_i | input | 5 | Trim magnitude, 0 to 31 steps |
| cal_speedup_i | input | 1 | Trim direction: 1 speed up, 0 slow down |
| sec_tick_o | output | 1 | One-cycle pulse at each second boundary |
| test_wave_o | output | 1 | Untrimmed square wave for frequency measurement |

## Verification
The bench builds the block with DIV_LOG2=6, SLOT_LOG2=2, PERIOD_SECS=16 and TEST_LOG2=4. This gives 64-tick seconds made of sixteen 4-tick slots, and a 256-slot period. The period is still large enough to hold the full 248-slot speed-up budget, so every one of the 64 calibration codes can be run through complete correction periods in a few thousand cycles each. With a 16-tick test wave, its level changes many times per second, so the wave is checked often. A bench model computes the length of each second from its position in the period. The bench compares every pulse and every change of the test wave against that model under dense, sparse and stopped reference ticks, and with a calibration change in the middle of a period.

// File: rtl/rtc_trim_pkg.sv
// Shared types for the trimmed timekeeping prescaler.
// Assumes: the trim magnitude field is five bits wide.
package rtc_trim_pkg;

    localparam int TRIM_MAG_W = 5;

    // Calibration word as captured at a period boundary
    typedef struct packed {
        logic                  speedup;
        logic [TRIM_MAG_W-1:0] mag;
    } trim_cal_t;

    // Length variant applied to the slot in progress
    typedef enum logic [1:0] {
        SLOT_NOMINAL = 2'd0,
        SLOT_SHORT   = 2'd1,
        SLOT_LONG    = 2'd2
    } slot_mode_e;

    // Width needed to hold the largest per-period slot budget
    function automatic int budget_width(int pos_step, int neg_step);
        int big;
        big = (pos_step > neg_step) ? pos_step : neg_step;
        return $clog2(big * ((1 << TRIM_MAG_W) - 1) + 1);
    endfunction

endpackage

// File: rtl/trim_budget.sv
// Converts the captured calibration word into a count of slots to adjust
// in the current correction period.
// Assumes: the step sizes are small constants; the product fits BUD_W bits.
module trim_budget
    import rtc_trim_pkg::*;
#(
    parameter int POS_STEP = 8,
    parameter int NEG_STEP = 4,
    localparam int BUD_W   = budget_width(POS_STEP, NEG_STEP)
) (
    input  trim_cal_t          cal_i,
    output logic [BUD_W-1:0]   budget_o
);

    logic [BUD_W-1:0] step_w;

    // Select slots per step from the trim direction
    always_comb begin
        step_w = cal_i.speedup ? BUD_W'(POS_STEP) : BUD_W'(NEG_STEP);
    end

    // Scale the magnitude by the step size
    always_comb begin
        budget_o = BUD_W'(cal_i.mag) * step_w;
    end

endmodule

// File: rtl/trim_slot_timer.sv
// Counts accepted reference ticks inside one slot and flags the tick that
// ends it. The slot is 2^SLOT_LOG2 ticks long, one less when short, or
// one more when long.
// Assumes: mode_i is stable for the whole slot; SLOT_LOG2 >= 2.
module trim_slot_timer
    import rtc_trim_pkg::*;
#(
    parameter int SLOT_LOG2 = 12,
    localparam int CW        = SLOT_LOG2 + 1,
    localparam int NOM_LAST  = (1 << SLOT_LOG2) - 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        advance_i,
    input  slot_mode_e  mode_i,
    output logic        slot_end_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_w;

    // Pick the final count for the slot variant
    always_comb begin
        unique case (mode_i)
            SLOT_SHORT: last_w = CW'(NOM_LAST - 1);
            SLOT_LONG:  last_w = CW'(NOM_LAST + 1);
            default:    last_w = CW'(NOM_LAST);
        endcase
    end

    // Flag the accepted tick that completes the slot
    always_comb begin
        slot_end_o = advance_i && (cnt_q == last_w);
    end

    // Step the in-slot count, wrapping at the slot end
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (slot_end_o) begin
            cnt_q <= '0;
        end else if (advance_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assert_slot_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !advance_i |=> $stable(cnt_q));

    assert_slot_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(NOM_LAST + 1));

endmodule

// File: rtl/trim_period_seq.sv
// Tracks the slot position inside the second and inside the correction
// period, holds the calibration for the period, and chooses each slot's
// length variant. The first `budget_i` slots of a period are adjusted.
// Assumes: a period is a whole number of seconds, and a second a whole
// power-of-two number of slots.
module trim_period_seq
    import rtc_trim_pkg::*;
#(
    parameter int DIV_LOG2    = 15,
    parameter int SLOT_LOG2   = 12,
    parameter int PERIOD_SECS = 60,
    parameter int BUD_W       = 8,
    localparam int SPS_W      = DIV_LOG2 - SLOT_LOG2,
    localparam int SLOTS_PER  = PERIOD_SECS * (1 << SPS_W),
    localparam int IDX_W      = $clog2(SLOTS_PER),
    localparam int CMP_W      = (IDX_W > BUD_W) ? IDX_W : BUD_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             slot_end_i,
    input  trim_cal_t        cal_i,
    input  logic [BUD_W-1:0] budget_i,
    output trim_cal_t        cal_q_o,
    output slot_mode_e       mode_o,
    output logic             sec_end_o
);

    logic [SPS_W-1:0] sub_q;
    logic [IDX_W-1:0] idx_q;
    logic             period_end;
    logic             in_budget;

    // A second ends on the last slot of its slot group
    always_comb begin
        sec_end_o  = slot_end_i && (&sub_q);
        period_end = slot_end_i && (idx_q == IDX_W'(SLOTS_PER - 1));
    end

    // Adjust a slot while its period index is below the budget
    always_comb begin
        in_budget = CMP_W'(idx_q) < CMP_W'(budget_i);
        if (!in_budget) begin
            mode_o = SLOT_NOMINAL;
        end else if (cal_q_o.speedup) begin
            mode_o = SLOT_SHORT;
        end else begin
            mode_o = SLOT_LONG;
        end
    end

    // Step the slot-in-second counter (wraps at a power of two)
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sub_q <= '0;
        end else if (slot_end_i) begin
            sub_q <= sub_q + SPS_W'(1);
        end
    end

    // Step the slot-in-period index, wrapping at the period end
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (period_end) begin
            idx_q <= '0;
        end else if (slot_end_i) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Capture the calibration during reset and at each period boundary
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cal_q_o <= cal_i;
        end else if (period_end) begin
            cal_q_o <= cal_i;
        end
    end

    assert_period_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end |-> sec_end_o);

    assert_cal_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !period_end |=> $stable(cal_q_o));

    assert_zero_trim_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (budget_i == '0) |-> (mode_o == SLOT_NOMINAL));

endmodule

// File: rtl/trim_test_div.sv
// Free-running divider of accepted reference ticks whose top bit forms
// the untrimmed test square wave.
// Assumes: TEST_LOG2 >= 1.
module trim_test_div #(
    parameter int TEST_LOG2 = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic advance_i,
    output logic wave_o
);

    logic [TEST_LOG2-1:0] div_q;

    // Count accepted ticks with no trim applied
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (advance_i) begin
            div_q <= div_q + TEST_LOG2'(1);
        end
    end

    // Expose the divider's top bit as the wave
    always_comb begin
        wave_o = div_q[TEST_LOG2-1];
    end

    assert_test_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !advance_i |=> $stable(wave_o));

endmodule

// File: rtl/rtc_trim_prescaler.sv
// Top of the trimmed timekeeping prescaler. Accepted reference ticks drive
// a slot timer; a sequencer groups slots into seconds and correction
// periods and applies the trim; a separate divider makes the test wave.
// Assumes: ref_tick_i is a one-cycle enable synchronous to clk_i.
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int DIV_LOG2    = 15,
    parameter int SLOT_LOG2   = 12,
    parameter int PERIOD_SECS = 60,
    parameter int TEST_LOG2   = 6,
    parameter int POS_STEP    = 8,
    parameter int NEG_STEP    = 4,
    localparam int BUD_W      = budget_width(POS_STEP, NEG_STEP)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ref_tick_i,
    input  logic                  osc_stop_i,
    input  logic [TRIM_MAG_W-1:0] cal_mag_i,
    input  logic                  cal_speedup_i,
    output logic                  sec_tick_o,
    output logic                  test_wave_o
);

    logic             advance;
    logic             slot_end;
    logic             sec_end;
    slot_mode_e       mode;
    trim_cal_t        cal_in;
    trim_cal_t        cal_q;
    logic [BUD_W-1:0] budget;

    // Accept a reference tick only while the timebase runs
    always_comb begin
        advance = ref_tick_i && !osc_stop_i;
        cal_in  = '{speedup: cal_speedup_i, mag: cal_mag_i};
    end

    trim_slot_timer #(
        .SLOT_LOG2 (SLOT_LOG2)
    ) u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .advance_i  (advance),
        .mode_i     (mode),
        .slot_end_o (slot_end)
    );

    trim_period_seq #(
        .DIV_LOG2    (DIV_LOG2),
        .SLOT_LOG2   (SLOT_LOG2),
        .PERIOD_SECS (PERIOD_SECS),
        .BUD_W       (BUD_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .slot_end_i (slot_end),
        .cal_i      (cal_in),
        .budget_i   (budget),
        .cal_q_o    (cal_q),
        .mode_o     (mode),
        .sec_end_o  (sec_end)
    );

    trim_budget #(
        .POS_STEP (POS_STEP),
        .NEG_STEP (NEG_STEP)
    ) u_budget (
        .cal_i    (cal_q),
        .budget_o (budget)
    );

    trim_test_div #(
        .TEST_LOG2 (TEST_LOG2)
    ) u_test (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .advance_i (advance),
        .wave_o    (test_wave_o)
    );

    // Register the second boundary into a one-cycle pulse
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sec_tick_o <= 1'b0;
        end else begin
            sec_tick_o <= sec_end;
        end
    end

    assert_stop_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_stop_i |=> !sec_tick_o);

    assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_tick_o |=> !sec_tick_o);

endmodule

// File: tb/rtc_trim_prescaler_bench.sv
`timescale 1ns/1ps
module rtc_trim_prescaler_bench;

    localparam int DIV   = 6;
    localparam int SLOT  = 2;
    localparam int PSECS = 16;
    localparam int TST   = 4;
    localparam int POS   = 8;
    localparam int NEG   = 4;
    localparam int SPS   = 1 << (DIV - SLOT);

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_tick;
    logic       osc_stop;
    logic [4:0] cal_mag;
    logic       cal_speedup;
    logic       sec_tick;
    logic       test_wave;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int free_cnt, tsec, sec_in_per, periods;
    logic [5:0] mcal;
    logic [5:0] prev_cal;
    logic prev_tick, prev_stop, last_sec, last_wave, sparse, done;
    string phase;

    always #2 clk = ~clk;

    rtc_trim_prescaler #(
        .DIV_LOG2 (DIV), .SLOT_LOG2 (SLOT), .PERIOD_SECS (PSECS),
        .TEST_LOG2 (TST), .POS_STEP (POS), .NEG_STEP (NEG)
    ) u_rtc_trim_prescaler (
        .clk_i (clk), .rst_ni (rst_n), .ref_tick_i (ref_tick),
        .osc_stop_i (osc_stop), .cal_mag_i (cal_mag),
        .cal_speedup_i (cal_speedup), .sec_tick_o (sec_tick),
        .test_wave_o (test_wave)
    );

    // Expected length of second s of a period under calibration c
    function automatic int sec_len(int s, logic [5:0] c);
        int m, n, k;
        m = int'(c[4:0]);
        n = c[5] ? POS * m : NEG * m;
        k = n - s * SPS;
        if (k < 0) k = 0;
        if (k > SPS) k = SPS;
        return (1 << DIV) + (c[5] ? -k : k);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: capture applied inputs, update model, compare, drive
    task step();
        bit accept, exp_pulse;
        string ctag;
        @(posedge clk);
        prev_tick = ref_tick;
        prev_stop = osc_stop;
        prev_cal  = {cal_speedup, cal_mag};
        @(negedge clk);
        cyc++;
        accept    = prev_tick && !prev_stop;
        exp_pulse = 1'b0;
        ctag = (mcal[4:0] == 5'd0) ? "R2" : (mcal[5] ? "R4 R5" : "R3 R5");
        if (accept) begin
            free_cnt++;
            tsec++;
            if (tsec == sec_len(sec_in_per, mcal)) begin
                exp_pulse = 1'b1;
                tsec = 0;
                sec_in_per++;
                if (sec_in_per == PSECS) begin
                    sec_in_per = 0;
                    mcal = prev_cal;
                    periods++;
                end
            end
        end
        if (exp_pulse || sec_tick)
            check(sec_tick == exp_pulse, {phase, " ", ctag, " R9 second pulse"},
                  int'(sec_tick), int'(exp_pulse));
        if (sec_tick && last_sec)
            check(1'b0, "R9 pulse longer than one cycle", 1, 0);
        if (accept)
            check(test_wave == ((free_cnt >> (TST - 1)) & 1), "R8 test wave",
                  int'(test_wave), (free_cnt >> (TST - 1)) & 1);
        if (prev_stop) begin
            check(!sec_tick, "R7 pulse while stopped", int'(sec_tick), 0);
            check(test_wave == last_wave, "R7 test wave moved while stopped",
                  int'(test_wave), int'(last_wave));
        end
        last_sec  = sec_tick;
        last_wave = test_wave;
        ref_tick  = sparse ? (cyc % 5 == 0) : (cyc % 7 != 3);
    endtask

    task automatic run_periods(int n);
        int target;
        target = periods + n;
        while (periods < target) step();
    endtask

    initial begin
        done = 1'b0;
        rst_n = 1'b0; ref_tick = 1'b0; osc_stop = 1'b0;
        cal_mag = 5'd0; cal_speedup = 1'b0; sparse = 1'b0;
        phase = "sweep";
        repeat (4) @(negedge clk);
        free_cnt = 0; tsec = 0; sec_in_per = 0; periods = 0;
        mcal = 6'd0; last_sec = 1'b0; last_wave = 1'b0;
        check(sec_tick == 1'b0, "R1 pulse in reset", int'(sec_tick), 0);
        check(test_wave == 1'b0, "R1 wave in reset", int'(test_wave), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(sec_tick == 1'b0, "R1 pulse after reset", int'(sec_tick), 0);
        check(test_wave == 1'b0, "R1 wave after reset", int'(test_wave), 0);

        // Every calibration code, each over a full period (R2 R3 R4 R5)
        for (int v = 0; v < 64; v++) begin
            {cal_speedup, cal_mag} = 6'(v);
            run_periods(1);
        end
        {cal_speedup, cal_mag} = 6'd0;
        run_periods(1);

        // Mid-period change must wait for the boundary (R6)
        phase = "R6";
        {cal_speedup, cal_mag} = 6'b100101;
        run_periods(1);
        while (sec_in_per != PSECS / 2) step();
        {cal_speedup, cal_mag} = 6'b011111;
        run_periods(2);

        // Oscillator stop in the middle of a second (R7)
        phase = "R7";
        while (tsec != 20) step();
        osc_stop = 1'b1;
        repeat (300) step();
        osc_stop = 1'b0;
        run_periods(1);

        // Sparse reference ticks (R10)
        phase = "R10";
        sparse = 1'b1;
        {cal_speedup, cal_mag} = 6'b100011;
        run_periods(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule